// File: doc/BRIEF.md
# File Register Clear, Complement and Decrement Unit

This unit carries out four byte-wide operations against a working accumulator and a register file of 128 locations: clearing a file location, clearing the accumulator, inverting a file location, and subtracting one from a file location. The register file sits outside the unit. The unit drives its address, takes the read data back in the same cycle, and returns a write strobe with write data. The accumulator and the zero flag are held inside the unit.

The caller presents one operation per cycle with a valid strobe, a two-bit operation code, a seven-bit file address and a destination bit. For the invert and decrement operations, the destination bit sends the result to the accumulator (0) or back to the addressed file location (1). Both clear operations force the zero flag to 1 whatever the destination bit says. The other two set the flag from their own 8-bit result.

The reset input is asynchronous and active low. It is released synchronously through a two-stage synchronizer, so the unit accepts operations from the third rising edge after release.

Top module: `fileop_unit`

## Requirements
- R1: While reset is active, and until it has been released through the synchronizer, the file write strobe stays low and the accumulator and zero flag read 00h and 0.
- R2: The operation code is 00 clear-file, 01 clear-accumulator, 10 invert-file, 11 decrement-file. A cycle with the valid strobe low writes no file location and leaves the accumulator and zero flag unchanged.
- R3: Clear-file drives write data 00h to the addressed location in the same cycle and leaves the accumulator unchanged.
- R4: Clear-accumulator loads 00h into the accumulator at the clock edge and writes no file location.
- R5: Invert-file produces the bitwise inverse of the byte read from the addressed location.
- R6: Decrement-file produces the byte read minus one, modulo 256, so 00h becomes FFh.
- R7: For invert and decrement, destination 0 loads the result into the accumulator at the edge and writes no file location. Destination 1 asserts the write strobe with the result at the addressed location in the same cycle and leaves the accumulator unchanged.
- R8: Every valid operation updates the zero flag at its clock edge. Invert and decrement set it exactly when their 8-bit result is 00h, and clear it otherwise.
- R9: A file write lands at the end of its cycle, so the next operation on the same address reads the new value.
- R10: Both clear operations ignore the destination bit and set the zero flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | Operation select (see R2) |
| op_addr | input | 7 | File location address |
| op_dest | input | 1 | Destination: 0 accumulator, 1 file location |
| rf_addr | output | 7 | Register file address |
| rf_rdata | input | 8 | Register file read data for rf_addr, same cycle |
| rf_we | output | 1 | Register file write strobe, taken at the clock edge |
| rf_wdata | output | 8 | Register file write data |
| w_q | output | 8 | Accumulator |
| z_q | output | 1 | Zero flag |

## Verification
Two things can happen in the same cycle: a write back to a file location, and a zero-flag update computed from the value that is overwritten. Back-to-back operations on a single address exercise this, for example clear, then decrement to FFh, then invert twice. Each step reads what the step before it wrote. The bench judges each step against a behavioural model: the write strobe and data are checked mid-cycle, and the flag, the accumulator and the stored byte are checked half a cycle after the edge.

// File: rtl/fileop_pkg.sv
package fileop_pkg;

  typedef enum logic [1:0] {
    FOP_CLR_FILE = 2'b00,
    FOP_CLR_ACC  = 2'b01,
    FOP_INV      = 2'b10,
    FOP_DEC      = 2'b11
  } fop_e;

  typedef struct packed {
    logic to_file;
    logic to_acc;
    logic flag_upd;
    logic force_zero;
  } fop_route_t;

endpackage

// File: rtl/fileop_rst_sync.sv
module fileop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fileop_decode.sv
module fileop_decode
  import fileop_pkg::*;
(
  input  logic       valid,
  input  fop_e       op,
  input  logic       dest,
  output fop_route_t route
);

  logic is_clear;
  logic is_arith;

  always_comb begin
    is_clear = (op == FOP_CLR_FILE) || (op == FOP_CLR_ACC);
    is_arith = (op == FOP_INV) || (op == FOP_DEC);

    route.to_file    = valid && ((op == FOP_CLR_FILE) || (is_arith && dest));
    route.to_acc     = valid && ((op == FOP_CLR_ACC)  || (is_arith && !dest));
    route.flag_upd   = valid;
    route.force_zero = is_clear;
  end

endmodule

// File: rtl/fileop_alu.sv
module fileop_alu
  import fileop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fop_e              op,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              is_zero
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      FOP_INV: result = ~operand;
      FOP_DEC: result = operand - ONE;
      default: result = '0;
    endcase
    is_zero = (result == '0);
  end

endmodule

// File: rtl/fileop_acc_regs.sv
module fileop_acc_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [DATA_W-1:0] acc_d,
  input  logic              flag_en,
  input  logic              flag_d,
  output logic [DATA_W-1:0] acc_q,
  output logic              flag_q
);

  logic [DATA_W-1:0] acc_nxt;
  logic              flag_nxt;

  always_comb begin
    acc_nxt  = acc_q;
    flag_nxt = flag_q;
    if (acc_en)  acc_nxt  = acc_d;
    if (flag_en) flag_nxt = flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      flag_q <= flag_nxt;
    end
  end

endmodule

// File: rtl/fileop_unit.sv
module fileop_unit
  import fileop_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 7,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dest,
  output logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [DATA_W-1:0] w_q,
  output logic              z_q
);

  logic              rst_sync_n;
  logic              valid_gated;
  fop_e              op;
  fop_route_t        route;
  logic [DATA_W-1:0] result;
  logic              res_zero;

  fileop_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign valid_gated = op_valid && rst_sync_n;
  assign op          = fop_e'(op_code);

  fileop_decode u_dec (
    .valid (valid_gated),
    .op    (op),
    .dest  (op_dest),
    .route (route)
  );

  fileop_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op),
    .operand (rf_rdata),
    .result  (result),
    .is_zero (res_zero)
  );

  fileop_acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc_en  (route.to_acc),
    .acc_d   (result),
    .flag_en (route.flag_upd),
    .flag_d  (route.force_zero | res_zero),
    .acc_q   (w_q),
    .flag_q  (z_q)
  );

  assign rf_addr  = op_addr;
  assign rf_we    = route.to_file;
  assign rf_wdata = result;

endmodule

// File: rtl/fileop_unit_chk.sv
module fileop_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic [ADDR_W-1:0] op_addr,
  input logic              op_dest,
  input logic [ADDR_W-1:0] rf_addr,
  input logic [DATA_W-1:0] rf_rdata,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [DATA_W-1:0] w_q,
  input logic              z_q
);

  // R1
  always_comb begin
    if (!rst_sync_n) rst_no_write_chk: assert (!rf_we);
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> ($stable(w_q) && $stable(z_q)));

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |-> !rf_we);

  // R3
  clr_file_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == 2'b00) |-> (rf_we && rf_wdata == '0 && rf_addr == op_addr));

  // R4
  clr_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == 2'b01) |=> (w_q == '0));

  // R5
  inv_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == 2'b10 && !op_dest) |=> (w_q == ~$past(rf_rdata)));

  // R6
  dec_file_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == 2'b11 && op_dest) |-> (rf_we && rf_wdata == DATA_W'(rf_rdata - 1'b1)));

  // R7
  acc_dest_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code[1] && !op_dest) |-> !rf_we);

  // R7
  file_dest_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code[1] && op_dest) |=> $stable(w_q));

  // R8
  dec_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == 2'b11) |=> (z_q == ($past(rf_rdata) == DATA_W'(1))));

  // R10
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code[1] == 1'b0) |=> z_q);

endmodule

bind fileop_unit fileop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_addr    (op_addr),
  .op_dest    (op_dest),
  .rf_addr    (rf_addr),
  .rf_rdata   (rf_rdata),
  .rf_we      (rf_we),
  .rf_wdata   (rf_wdata),
  .w_q        (w_q),
  .z_q        (z_q)
);

// File: tb/fileop_unit_tb.sv
`timescale 1ns/1ps
module fileop_unit_tb_top;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [1:0] op_code;
  logic [6:0] op_addr;
  logic       op_dest;
  logic [6:0] rf_addr;
  logic [7:0] rf_rdata;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] w_q;
  logic       z_q;

  logic [7:0] file_mem [128];
  logic [7:0] ref_mem  [128];
  logic [7:0] ref_w;
  logic       ref_z;
  int         n_checks;
  int         n_fail;
  bit         done;

  fileop_unit dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_addr  (op_addr),
    .op_dest  (op_dest),
    .rf_addr  (rf_addr),
    .rf_rdata (rf_rdata),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata),
    .w_q      (w_q),
    .z_q      (z_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // register file owned by the bench; preset while reset is low
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) file_mem[i] <= seed_val(i);
    end else if (rf_we) begin
      file_mem[rf_addr] <= rf_wdata;
    end
  end
  assign rf_rdata = file_mem[rf_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit v, input logic [1:0] op, input logic [6:0] a, input bit d);
    logic [7:0] src, res;
    bit         exp_we, exp_acc;
    string      rq;
    op_valid = v; op_code = op; op_addr = a; op_dest = d;
    src = ref_mem[a];
    case (op)
      2'b10:   res = ~src;
      2'b11:   res = src - 8'd1;
      default: res = 8'h00;
    endcase
    exp_we  = v && (op == 2'b00 || (op[1] && d));
    exp_acc = v && (op == 2'b01 || (op[1] && !d));
    case (op)
      2'b00: rq = "R3";
      2'b01: rq = "R4";
      2'b10: rq = "R5";
      default: rq = "R6";
    endcase
    #0.5;
    if (!v)            check(rf_we == 1'b0, "R2 idle write", int'(rf_we), 0);
    else if (!op[1])   check(rf_we == exp_we, "R10 clear write strobe", int'(rf_we), int'(exp_we));
    else               check(rf_we == exp_we, "R7 write strobe", int'(rf_we), int'(exp_we));
    if (exp_we) begin
      check(rf_wdata == res, rq, int'(rf_wdata), int'(res));
      check(rf_addr == a, "R7 address", int'(rf_addr), int'(a));
    end
    @(posedge clk);
    if (exp_we)  ref_mem[a] = res;
    if (exp_acc) ref_w = res;
    if (v)       ref_z = (res == 8'h00);
    @(negedge clk);
    check(w_q == ref_w, v ? rq : "R2 acc hold", int'(w_q), int'(ref_w));
    check(z_q == ref_z, v ? (op[1] ? "R8" : "R10") : "R2 flag hold", int'(z_q), int'(ref_z));
    check(file_mem[a] == ref_mem[a], "R9 stored byte", int'(file_mem[a]), int'(ref_mem[a]));
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    for (int i = 0; i < 128; i++) ref_mem[i] = seed_val(i);
    ref_w = 8'h00; ref_z = 1'b0;
    op_valid = 1'b1; op_code = 2'b00; op_addr = 7'd5; op_dest = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: valid clear request is blocked during reset
    check(rf_we == 1'b0, "R1 write in reset", int'(rf_we), 0);
    check(w_q == 8'h00, "R1 acc reset", int'(w_q), 0);
    check(z_q == 1'b0, "R1 flag reset", int'(z_q), 0);
    rst_n = 1'b1;
    op_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(z_q == 1'b0 && w_q == 8'h00, "R1 after release", int'({w_q, z_q}), 0);

    run_op(1, 2'b10, 7'd3, 0);    // R5 invert into accumulator
    run_op(1, 2'b01, 7'd4, 1);    // R4/R10 clear accumulator, dest ignored
    run_op(1, 2'b11, 7'd10, 1);   // R6 decrement back to file
    run_op(1, 2'b00, 7'd10, 0);   // R10 clear file with dest 0
    run_op(1, 2'b11, 7'd10, 1);   // R6/R8 00h -> FFh, flag 0
    run_op(1, 2'b10, 7'd10, 1);   // R9 chain: FFh -> 00h, flag 1
    run_op(1, 2'b10, 7'd10, 1);   // 00h -> FFh
    run_op(1, 2'b00, 7'd20, 1);
    run_op(1, 2'b10, 7'd20, 1);
    run_op(1, 2'b10, 7'd20, 1);
    run_op(1, 2'b00, 7'd21, 1);
    run_op(1, 2'b10, 7'd21, 1);   // FFh
    run_op(1, 2'b11, 7'd21, 1);   // FEh
    run_op(1, 2'b10, 7'd21, 1);   // 01h
    run_op(1, 2'b11, 7'd21, 0);   // R8 01h - 1 = 0 into accumulator, flag 1
    run_op(0, 2'b00, 7'd21, 1);   // R2 invalid clear ignored
    run_op(0, 2'b01, 7'd22, 0);   // R2 invalid clear-accumulator ignored
    run_op(1, 2'b11, 7'd127, 0);  // top address
    run_op(1, 2'b10, 7'd0, 1);    // bottom address

    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run_op(lfsr[15:13] != 3'b000, lfsr[1:0], {4'b0, lfsr[8:6]}, lfsr[4]);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule